// File: doc/BRIEF.md
# Boot-Block Address Map and Write Guard

This block sits beside the array controller of a 1 MB byte-wide flash. It maps a 20-bit byte address onto the 19 erase blocks of an asymmetric layout. The layout has one 16 KB boot block, two 8 KB parameter blocks, one 32 KB main block and fifteen 64 KB main blocks. A parameter places the boot block at the top or at the bottom of the address space. The map returns the block index, base and size for any address. Indices always ascend with address.

The block also keeps one protection bit per block. It combines that bit with a temporary-override input to tell the program and erase logic whether a write may proceed. For a multi-block erase, it reduces a 19-bit request mask to the blocks that may actually be erased.

A small sequencer runs the protect and unprotect operations. Each operation has its duration set in clock cycles. Protect sets the bit of one block. Unprotect clears every bit, but only when all bits are already set. A verify output reports the state of the block that the operation selector points at.

Sequencer states:
- `ST_IDLE`: accepts requests.
- `ST_PROTECT`: counts down, then sets the latched block's bit.
- `ST_UNPROTECT`: counts down, then clears all bits.

Sequencer transitions:
- IDLE→PROTECT on a protect request.
- IDLE→UNPROTECT on an unprotect request while all blocks are protected.
- PROTECT→IDLE when its count expires.
- UNPROTECT→IDLE when its count expires.

Top module: `boot_map_guard`

## Requirements
- R1: `blk_idx`, `blk_base` and `blk_size` are combinational from `addr`. `blk_base` ≤ `addr` < `blk_base`+`blk_size`. Block indices ascend with address, from 0 to 18.
- R2: With `BOOT_AT_TOP`=1 the layout from address 0 is fifteen 64 KB blocks (index 0–14), then 32 KB at F0000h (index 15), 8 KB at F8000h (16), 8 KB at FA000h (17) and 16 KB at FC000h (18). With `BOOT_AT_TOP`=0 the layout is mirrored: 16 KB at 0 (index 0), 8 KB at 4000h (1), 8 KB at 6000h (2), 32 KB at 8000h (3), then 64 KB blocks from 10000h (4–18).
- R3: After reset every block is unprotected and `op_busy` is 0.
- R4: `wr_ok` is 0 when the block holding `addr` is protected and `temp_unprot` is 0. Otherwise it is 1. Releasing `temp_unprot` restores the earlier refusal with no change to the protection bits.
- R5: `erase_ok` bit i (for block i) equals `erase_mask` bit i, cleared when block i is protected and `temp_unprot` is 0.
- R6: `verify_data` is 01h when the block selected by `op_sel` (address bits 19..13) is protected and 00h when it is not.
- R7: A protect request seen in `ST_IDLE` makes `op_busy` 1 from the next edge. Exactly `PROT_CYCLES` edges after the request edge, `op_busy` returns to 0 and the block latched at the request is protected. No protection bit changes while idle.
- R8: An unprotect request seen in `ST_IDLE` with all 19 blocks protected keeps `op_busy` at 1 for `UNPROT_CYCLES` edges and then clears every bit. With any block unprotected, the request is ignored and `op_busy` stays 0.
- R9: Requests arriving while `op_busy` is 1 are ignored. When both requests arrive together in `ST_IDLE`, protect wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Byte address to classify |
| temp_unprot | input | 1 | Temporary override of protection while 1 |
| erase_mask | input | 19 | Requested blocks for multi-block erase, bit i = block i |
| op_sel | input | 7 | Address bits 19..13 choosing the block for protect or verify |
| prot_req | input | 1 | Start a protect of the selected block |
| unprot_req | input | 1 | Start a bulk unprotect |
| blk_idx | output | 5 | Index of block holding `addr` |
| blk_base | output | 20 | Base address of that block |
| blk_size | output | 17 | Size in bytes of that block |
| wr_ok | output | 1 | Program or erase at `addr` may proceed |
| erase_ok | output | 19 | Permitted subset of `erase_mask` |
| op_busy | output | 1 | Protect or unprotect in progress |
| verify_data | output | 8 | 01h if selected block protected, else 00h |

## Verification
Map outputs, `wr_ok`, `erase_ok` and `verify_data` are combinational. The bench reads them 1 ns after it changes an input, and never across a clock edge. `op_busy` is registered, so it is read after the first edge that samples a request. Protection results land on the edge exactly `PROT_CYCLES` or `UNPROT_CYCLES` edges after the request edge. The bench therefore samples once on the edge before that one, expecting busy with the old bits, and once on that edge, expecting idle with the new bits. Expected geometry comes from a size list walked in the bench.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;
    localparam int ADDR_W  = 20;
    localparam int NBLK    = 19;
    localparam int IDX_W   = $clog2(NBLK);
    localparam int SEL_LSB = 13;
    localparam int SEL_W   = ADDR_W - SEL_LSB;
    localparam int SIZE_W  = 17;

    localparam logic [SIZE_W-1:0] SZ_64K = SIZE_W'(17'h10000);
    localparam logic [SIZE_W-1:0] SZ_32K = SIZE_W'(17'h08000);
    localparam logic [SIZE_W-1:0] SZ_16K = SIZE_W'(17'h04000);
    localparam logic [SIZE_W-1:0] SZ_8K  = SIZE_W'(17'h02000);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROTECT,
        ST_UNPROTECT
    } prot_state_t;
endpackage

// File: rtl/blk_decode.sv
module blk_decode
    import boot_map_pkg::*;
#(
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] idx
);
    // sel holds address bits 19..13: [6:3] = 64 KB slot, [2] = 32 KB half,
    // [1] = 16 KB quarter, [0] = 8 KB eighth.
    generate
        if (BOOT_AT_TOP) begin : g_top
            always_comb begin
                if (sel[6:3] != 4'hF)
                    idx = IDX_W'(sel[6:3]);
                else if (!sel[2])
                    idx = IDX_W'(15);
                else if (!sel[1])
                    idx = sel[0] ? IDX_W'(17) : IDX_W'(16);
                else
                    idx = IDX_W'(18);
            end
        end else begin : g_bot
            always_comb begin
                if (sel[6:3] != 4'h0)
                    idx = IDX_W'(sel[6:3]) + IDX_W'(3);
                else if (sel[2])
                    idx = IDX_W'(3);
                else if (sel[1])
                    idx = sel[0] ? IDX_W'(2) : IDX_W'(1);
                else
                    idx = IDX_W'(0);
            end
        end
    endgenerate
endmodule

// File: rtl/blk_geom.sv
module blk_geom
    import boot_map_pkg::*;
#(
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] size
);
    logic [IDX_W-1:0] slot;

    generate
        if (BOOT_AT_TOP) begin : g_top
            assign slot = idx;
            always_comb begin
                unique case (idx)
                    IDX_W'(15): begin base = 20'hF0000; size = SZ_32K; end
                    IDX_W'(16): begin base = 20'hF8000; size = SZ_8K;  end
                    IDX_W'(17): begin base = 20'hFA000; size = SZ_8K;  end
                    IDX_W'(18): begin base = 20'hFC000; size = SZ_16K; end
                    default:    begin base = {slot[3:0], 16'h0}; size = SZ_64K; end
                endcase
            end
        end else begin : g_bot
            assign slot = idx - IDX_W'(3);
            always_comb begin
                unique case (idx)
                    IDX_W'(0): begin base = 20'h00000; size = SZ_16K; end
                    IDX_W'(1): begin base = 20'h04000; size = SZ_8K;  end
                    IDX_W'(2): begin base = 20'h06000; size = SZ_8K;  end
                    IDX_W'(3): begin base = 20'h08000; size = SZ_32K; end
                    default:   begin base = {slot[3:0], 16'h0}; size = SZ_64K; end
                endcase
            end
        end
    endgenerate

    logic unused_slot_hi;
    assign unused_slot_hi = slot[IDX_W-1];
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
    import boot_map_pkg::*;
#(
    parameter int PROT_CYCLES   = 10000,
    parameter int UNPROT_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_req,
    input  logic             unprot_req,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [NBLK-1:0]  prot_bits,
    output logic             busy
);
    localparam int LONGEST = (PROT_CYCLES > UNPROT_CYCLES) ? PROT_CYCLES : UNPROT_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    prot_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] tgt;
    logic             all_prot;
    logic             cnt_done;

    assign all_prot = &prot_bits;
    assign cnt_done = (cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (prot_req)                    state_nx = ST_PROTECT;
                else if (unprot_req && all_prot) state_nx = ST_UNPROTECT;
            end
            ST_PROTECT:   if (cnt_done) state_nx = ST_IDLE;
            ST_UNPROTECT: if (cnt_done) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Counter, target and protection bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            tgt       <= '0;
            prot_bits <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (prot_req) begin
                        tgt <= sel_idx;
                        cnt <= CNT_W'(PROT_CYCLES - 1);
                    end else if (unprot_req && all_prot) begin
                        cnt <= CNT_W'(UNPROT_CYCLES - 1);
                    end
                end
                ST_PROTECT: begin
                    if (cnt_done) prot_bits[tgt] <= 1'b1;
                    else          cnt <= cnt - 1'b1;
                end
                ST_UNPROTECT: begin
                    if (cnt_done) prot_bits <= '0;
                    else          cnt <= cnt - 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/boot_map_guard.sv
module boot_map_guard
    import boot_map_pkg::*;
#(
    parameter bit BOOT_AT_TOP   = 1'b1,
    parameter int PROT_CYCLES   = 10000,
    parameter int UNPROT_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              temp_unprot,
    input  logic [NBLK-1:0]   erase_mask,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic              prot_req,
    input  logic              unprot_req,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [ADDR_W-1:0] blk_base,
    output logic [SIZE_W-1:0] blk_size,
    output logic              wr_ok,
    output logic [NBLK-1:0]   erase_ok,
    output logic              op_busy,
    output logic [7:0]        verify_data
);
    logic [IDX_W-1:0] op_idx;
    logic [NBLK-1:0]  prot_bits;
    logic [NBLK-1:0]  eff_prot;
    logic             unused_addr_lo;

    assign unused_addr_lo = ^addr[SEL_LSB-1:0];

    blk_decode #(.BOOT_AT_TOP(BOOT_AT_TOP)) u_dec_addr (
        .sel (addr[ADDR_W-1:SEL_LSB]),
        .idx (blk_idx)
    );

    blk_decode #(.BOOT_AT_TOP(BOOT_AT_TOP)) u_dec_op (
        .sel (op_sel),
        .idx (op_idx)
    );

    blk_geom #(.BOOT_AT_TOP(BOOT_AT_TOP)) u_geom (
        .idx  (blk_idx),
        .base (blk_base),
        .size (blk_size)
    );

    prot_ctrl #(
        .PROT_CYCLES   (PROT_CYCLES),
        .UNPROT_CYCLES (UNPROT_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_req   (prot_req),
        .unprot_req (unprot_req),
        .sel_idx    (op_idx),
        .prot_bits  (prot_bits),
        .busy       (op_busy)
    );

    assign eff_prot    = prot_bits & {NBLK{~temp_unprot}};
    assign wr_ok       = ~eff_prot[blk_idx];
    assign erase_ok    = erase_mask & ~eff_prot;
    assign verify_data = {7'b0, prot_bits[op_idx]};
endmodule

// File: rtl/boot_map_guard_chk.sv
module boot_map_guard_chk
    import boot_map_pkg::*;
#(
    parameter bit BOOT_AT_TOP = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              temp_unprot,
    input logic [NBLK-1:0]   erase_mask,
    input logic [SEL_W-1:0]  op_sel,
    input logic [IDX_W-1:0]  blk_idx,
    input logic [ADDR_W-1:0] blk_base,
    input logic [SIZE_W-1:0] blk_size,
    input logic              wr_ok,
    input logic [NBLK-1:0]   erase_ok,
    input logic              op_busy,
    input logic [7:0]        verify_data
);
    localparam logic [IDX_W-1:0] BOOT_IDX = BOOT_AT_TOP ? IDX_W'(NBLK - 1) : IDX_W'(0);

    AST_ADDR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr} >= {1'b0, blk_base}) &&
        ({1'b0, addr} < ({1'b0, blk_base} + (ADDR_W + 1)'(blk_size)))); // R1

    AST_BOOT_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_size == SZ_16K) |-> (blk_idx == BOOT_IDX)); // R2

    AST_OVERRIDE_PERMITS: assert property (@(posedge clk) disable iff (!rst_n)
        temp_unprot |-> (wr_ok && (erase_ok == erase_mask))); // R4

    AST_ERASE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((erase_ok & ~erase_mask) == '0)); // R5

    AST_VERIFY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_data[7:1] == 7'b0)); // R6

    AST_IDLE_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!op_busy) && !op_busy && $stable(op_sel)) |-> $stable(verify_data)); // R7
endmodule

bind boot_map_guard boot_map_guard_chk #(.BOOT_AT_TOP(BOOT_AT_TOP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .temp_unprot (temp_unprot),
    .erase_mask  (erase_mask),
    .op_sel      (op_sel),
    .blk_idx     (blk_idx),
    .blk_base    (blk_base),
    .blk_size    (blk_size),
    .wr_ok       (wr_ok),
    .erase_ok    (erase_ok),
    .op_busy     (op_busy),
    .verify_data (verify_data)
);

// File: tb/tb_boot_map_guard.sv
module tb_boot_map_guard;
    localparam int PC = 6;
    localparam int UC = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        temp_unprot = 1'b0;
    logic [18:0] erase_mask = '0;
    logic [6:0]  op_sel = '0;
    logic        prot_req = 1'b0;
    logic        unprot_req = 1'b0;

    logic [4:0]  blk_idx, b_idx;
    logic [19:0] blk_base, b_base;
    logic [16:0] blk_size, b_size;
    logic        wr_ok, b_wr_ok;
    logic [18:0] erase_ok, b_erase_ok;
    logic        op_busy, b_busy;
    logic [7:0]  verify_data, b_verify;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boot_map_guard #(.BOOT_AT_TOP(1'b1), .PROT_CYCLES(PC), .UNPROT_CYCLES(UC)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .temp_unprot(temp_unprot),
        .erase_mask(erase_mask), .op_sel(op_sel), .prot_req(prot_req),
        .unprot_req(unprot_req), .blk_idx(blk_idx), .blk_base(blk_base),
        .blk_size(blk_size), .wr_ok(wr_ok), .erase_ok(erase_ok),
        .op_busy(op_busy), .verify_data(verify_data)
    );

    boot_map_guard #(.BOOT_AT_TOP(1'b0), .PROT_CYCLES(PC), .UNPROT_CYCLES(UC)) dut_bot (
        .clk(clk), .rst_n(rst_n), .addr(addr), .temp_unprot(1'b0),
        .erase_mask(erase_mask), .op_sel(op_sel), .prot_req(1'b0),
        .unprot_req(1'b0), .blk_idx(b_idx), .blk_base(b_base),
        .blk_size(b_size), .wr_ok(b_wr_ok), .erase_ok(b_erase_ok),
        .op_busy(b_busy), .verify_data(b_verify)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int blk_sz(input int i, input bit top);
        if (!top) return blk_sz(18 - i, 1'b1);
        if (i < 15) return 65536;
        if (i == 15) return 32768;
        if (i == 18) return 16384;
        return 8192;
    endfunction

    function automatic int blk_start(input int i, input bit top);
        int b = 0;
        for (int k = 0; k < i; k++) b += blk_sz(k, top);
        return b;
    endfunction

    task automatic chk_map(input logic [19:0] a, input bit top);
        int ei = -1, eb = 0, es = 0;
        int ai, ab, as_;
        for (int i = 0; i < 19; i++)
            if (int'(a) >= blk_start(i, top) && int'(a) < blk_start(i, top) + blk_sz(i, top)) begin
                ei = i; eb = blk_start(i, top); es = blk_sz(i, top);
            end
        addr = a;
        #1;
        ai = top ? int'(blk_idx) : int'(b_idx);
        ab = top ? int'(blk_base) : int'(b_base);
        as_ = top ? int'(blk_size) : int'(b_size);
        check(ai == ei, top ? "R1 idx top" : "R2 idx bottom", ai, ei);
        check(ab == eb && as_ == es, top ? "R2 base/size top" : "R2 base/size bottom", {ab[19:4], as_[16:1]}, {eb[19:4], es[16:1]});
    endtask

    task automatic do_protect(input logic [19:0] a, input bit timed);
        op_sel = a[19:13];
        prot_req = 1'b1;
        step(1);
        prot_req = 1'b0;
        if (timed) begin
            check(op_busy == 1'b1, "R7 busy after request", op_busy, 1);
            step(PC - 1);
            check(op_busy == 1'b1 && verify_data == 8'h00, "R7 still busy, bit unchanged", {op_busy, verify_data}, 9'h100);
            step(1);
            check(op_busy == 1'b0 && verify_data == 8'h01, "R7 done, block protected", {op_busy, verify_data}, 9'h001);
        end else begin
            step(PC);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check(op_busy == 1'b0, "R3 idle after reset", op_busy, 0);
        erase_mask = '1;
        #1;
        check(erase_ok == 19'h7FFFF, "R3 all unprotected", erase_ok, 19'h7FFFF);
        op_sel = 7'h7F;
        #1;
        check(verify_data == 8'h00, "R3 boot block verify", verify_data, 0);
    endtask

    task automatic t_map;
        for (int i = 0; i < 19; i++) begin
            chk_map(20'(blk_start(i, 1'b1)), 1'b1);
            chk_map(20'(blk_start(i, 1'b1) + blk_sz(i, 1'b1) - 1), 1'b1);
            chk_map(20'(blk_start(i, 1'b0)), 1'b0);
            chk_map(20'(blk_start(i, 1'b0) + blk_sz(i, 1'b0) - 1), 1'b0);
        end
        chk_map(20'hFB7A5, 1'b1);
        chk_map(20'h05123, 1'b0);
    endtask

    task automatic t_protect_and_guard;
        do_protect(20'hFA000, 1'b1);      // block 17
        do_protect(20'h30000, 1'b1);      // block 3
        addr = 20'hFA123;
        temp_unprot = 1'b0;
        #1;
        check(wr_ok == 1'b0, "R4 protected block refused", wr_ok, 0);
        addr = 20'hF8000;
        #1;
        check(wr_ok == 1'b1, "R4 neighbour allowed", wr_ok, 1);
        addr = 20'h3FFFF;
        temp_unprot = 1'b1;
        #1;
        check(wr_ok == 1'b1, "R4 override permits", wr_ok, 1);
        erase_mask = '1;
        #1;
        check(erase_ok == 19'h7FFFF, "R5 override erase mask", erase_ok, 19'h7FFFF);
        step(2);
        temp_unprot = 1'b0;
        #1;
        check(wr_ok == 1'b0, "R4 protection restored", wr_ok, 0);
        check(erase_ok == (19'h7FFFF & ~19'h20008), "R5 erase subset", erase_ok, 19'h7FFFF & ~19'h20008);
        erase_mask = 19'h00C0F;
        #1;
        check(erase_ok == 19'h00C07, "R5 partial mask", erase_ok, 19'h00C07);
        op_sel = 7'h7D;                   // FA000 -> block 17
        #1;
        check(verify_data == 8'h01, "R6 protected verify", verify_data, 1);
        op_sel = 7'h00;
        #1;
        check(verify_data == 8'h00, "R6 unprotected verify", verify_data, 0);
    endtask

    task automatic t_unprot_refused;
        unprot_req = 1'b1;
        step(1);
        unprot_req = 1'b0;
        check(op_busy == 1'b0, "R8 refused when not all protected", op_busy, 0);
        step(UC + 1);
        op_sel = 7'h7D;
        #1;
        check(verify_data == 8'h01, "R8 bits kept after refusal", verify_data, 1);
    endtask

    task automatic t_busy_ignore;
        op_sel = 7'h00;                   // block 0
        prot_req = 1'b1;
        step(1);
        prot_req = 1'b0;
        step(1);
        op_sel = 7'h08;                   // 10000h -> block 1
        prot_req = 1'b1;
        unprot_req = 1'b1;
        step(1);
        prot_req = 1'b0;
        unprot_req = 1'b0;
        step(PC + 2);
        check(op_busy == 1'b0, "R9 idle after op", op_busy, 0);
        check(verify_data == 8'h00, "R9 request during busy ignored", verify_data, 0);
        op_sel = 7'h00;
        #1;
        check(verify_data == 8'h01, "R9 first target protected", verify_data, 1);
    endtask

    task automatic t_priority;
        op_sel = 7'h10;                   // 20000h -> block 2
        prot_req = 1'b1;
        unprot_req = 1'b1;
        step(1);
        prot_req = 1'b0;
        unprot_req = 1'b0;
        step(PC);
        check(verify_data == 8'h01, "R9 protect wins", verify_data, 1);
    endtask

    task automatic t_unprotect_all;
        for (int i = 0; i < 19; i++) do_protect(20'(blk_start(i, 1'b1)), 1'b0);
        erase_mask = '1;
        #1;
        check(erase_ok == 19'h0, "R8 all protected before bulk clear", erase_ok, 0);
        op_sel = 7'h7E;
        unprot_req = 1'b1;
        step(1);
        unprot_req = 1'b0;
        check(op_busy == 1'b1, "R8 busy on accepted unprotect", op_busy, 1);
        step(UC - 1);
        check(op_busy == 1'b1 && verify_data == 8'h01, "R8 still busy before end", {op_busy, verify_data}, 9'h101);
        step(1);
        check(op_busy == 1'b0 && verify_data == 8'h00, "R8 cleared at end", {op_busy, verify_data}, 9'h000);
        check(erase_ok == 19'h7FFFF, "R8 every block cleared", erase_ok, 19'h7FFFF);
    endtask

    initial begin
        t_reset();
        t_map();
        t_protect_and_guard();
        t_unprot_refused();
        t_busy_ignore();
        t_priority();
        t_unprotect_all();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule